// File: doc/BRIEF.md
# Protected Image Checksum Accumulator

This block folds a stream of 14-bit program memory words, two configuration words and four identification words into the 16-bit checksum that a device programmer reports for a flash image. A start strobe opens a run and samples a code-protect flag. Program words then arrive one per cycle, each with its address, and the last one is tagged. The configuration and identification words arrive together on a single metadata strobe. That strobe may come before, during or after the program-word stream.

When protection is off, the checksum is the sum of the program words in the user range plus the two masked configuration words. When protection is on, the program words are consumed without being added. In their place, the low nibbles of the four identification words are packed into one 16-bit value and added. The running sum keeps only its low 16 bits. The result is shown on `sum_o`, and `done_o` rises one cycle after both inputs of the run have been taken. Both outputs hold until the next start strobe.

Top module: `image_cksum`

## Requirements
- R1: After synchronous reset, `sum_o` is 0 and `done_o` is 0.
- R2: A start strobe sets `sum_o` to 0 and `done_o` to 0 at the next edge and samples `prot_i` for the new run. Any program word or metadata strobe presented in the same cycle as start is ignored.
- R3: With protection off, each accepted program word whose address is at most 0x0FFF is zero-extended to 16 bits and added to the sum.
- R4: A program word whose address is above 0x0FFF adds nothing, whether protection is on or off.
- R5: With protection on, program words are consumed, and their tag still counts toward completion, but they add nothing to the sum.
- R6: A metadata strobe adds (first configuration word AND 0x3FFF) plus (second configuration word AND 0x0003) in both modes.
- R7: With protection on, the metadata strobe also adds a packed value: ID word 0 bits 3:0 at bits 15:12, ID word 1 at 11:8, ID word 2 at 7:4 and ID word 3 at 3:0. The upper ID bits are ignored. With protection off, the ID words add nothing. On `id_words_i`, ID word k occupies bits 14k+13:14k.
- R8: The sum wraps modulo 2^16. An unprotected blank image gives 0x3002: 4096 words of 0x3FFF, with both configuration words at 0x3FFF.
- R9: `done_o` rises at the edge after the one at which the second of these two inputs is accepted: the tagged last program word and the metadata strobe. They may be accepted in either order or in the same cycle, and a program word and metadata taken in one cycle are both added.
- R10: In a run, program words after the tagged last one and metadata strobes after the first one are ignored. Before the first start and while `done_o` is high, all program words and metadata strobes are ignored, and `sum_o` and `done_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a new run, clears the sum |
| prot_i | input | 1 | Code-protect flag, sampled with start |
| pw_valid_i | input | 1 | Program word present this cycle |
| pw_last_i | input | 1 | Marks the final program word of the run |
| pw_addr_i | input | 14 | Address of the program word |
| pw_data_i | input | 14 | Program word value |
| meta_valid_i | input | 1 | Configuration and ID words present this cycle |
| cfg_a_i | input | 14 | First configuration word |
| cfg_b_i | input | 14 | Second configuration word |
| id_words_i | input | 56 | Four ID words, word k at bits 14k+13:14k |
| sum_o | output | 16 | Running and final checksum |
| done_o | output | 1 | Checksum complete, held until next start |

## Verification
Two events can fall in the same cycle: a program-word addition and the metadata addition. The same is true of the tagged last word and the metadata strobe, which close the run together. The stimulus table places the metadata strobe on an early word, on the final tagged word, and after the stream, and it repeats the strobe once to show the repeat is dropped. Each run is judged by comparing the final sum against a model built from the requirements, by checking that `done_o` is still low right after the closing edge, and by checking that it is high one edge later.

// File: rtl/image_cksum_pkg.sv
package image_cksum_pkg;

    localparam int WORD_W = 14;
    localparam int SUM_W  = 16;
    localparam int ADDR_W = 14;
    localparam int ID_NUM = 4;
    localparam int NIB_W  = 4;
    localparam int PACK_W = ID_NUM * NIB_W;
    localparam int IDS_W  = ID_NUM * WORD_W;

    localparam logic [ADDR_W-1:0] PROG_TOP   = 14'h0FFF;
    localparam logic [WORD_W-1:0] CFG_A_MASK = 14'h3FFF;
    localparam logic [WORD_W-1:0] CFG_B_MASK = 14'h0003;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef struct packed {
        logic             take;
        logic [SUM_W-1:0] val;
    } term_t;

    function automatic logic [SUM_W-1:0] widen(input logic [WORD_W-1:0] w);
        return SUM_W'(w);
    endfunction

endpackage

// File: rtl/image_cksum_seq.sv
module image_cksum_seq
    import image_cksum_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic prot_i,
    input  logic pw_valid_i,
    input  logic pw_last_i,
    input  logic meta_valid_i,
    output logic pw_fire_o,
    output logic meta_fire_o,
    output logic prot_q_o,
    output logic done_o
);

    phase_e phase_q;
    logic   pw_seen_q;
    logic   meta_seen_q;
    logic   prot_q;
    logic   live;

    assign live        = (phase_q == PH_RUN) && !start_i;
    assign pw_fire_o   = live && pw_valid_i && !pw_seen_q;
    assign meta_fire_o = live && meta_valid_i && !meta_seen_q;
    assign prot_q_o    = prot_q;
    assign done_o      = (phase_q == PH_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            pw_seen_q   <= 1'b0;
            meta_seen_q <= 1'b0;
            prot_q      <= 1'b0;
        end else if (start_i) begin
            phase_q     <= PH_RUN;
            pw_seen_q   <= 1'b0;
            meta_seen_q <= 1'b0;
            prot_q      <= prot_i;
        end else if (phase_q == PH_RUN) begin
            if (pw_fire_o && pw_last_i) pw_seen_q <= 1'b1;
            if (meta_fire_o)            meta_seen_q <= 1'b1;
            if (pw_seen_q && meta_seen_q) phase_q <= PH_DONE;
        end
    end

endmodule

// File: rtl/image_cksum_prog_term.sv
module image_cksum_prog_term
    import image_cksum_pkg::*;
(
    input  logic              fire_i,
    input  logic              prot_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] data_i,
    output term_t             term_o
);

    always_comb begin
        term_o.take = fire_i && !prot_i && (addr_i <= PROG_TOP);
        term_o.val  = term_o.take ? widen(data_i) : '0;
    end

endmodule

// File: rtl/image_cksum_meta_term.sv
module image_cksum_meta_term
    import image_cksum_pkg::*;
(
    input  logic              fire_i,
    input  logic              prot_i,
    input  logic [WORD_W-1:0] cfg_a_i,
    input  logic [WORD_W-1:0] cfg_b_i,
    input  logic [IDS_W-1:0]  ids_i,
    output term_t             term_o
);

    logic [PACK_W-1:0] packed_id;

    for (genvar k = 0; k < ID_NUM; k++) begin : g_nib
        assign packed_id[(ID_NUM-1-k)*NIB_W +: NIB_W] = ids_i[k*WORD_W +: NIB_W];
    end

    logic [SUM_W-1:0] cfg_part;
    logic [SUM_W-1:0] id_part;

    always_comb begin
        cfg_part    = widen(cfg_a_i & CFG_A_MASK) + widen(cfg_b_i & CFG_B_MASK);
        id_part     = prot_i ? SUM_W'(packed_id) : '0;
        term_o.take = fire_i;
        term_o.val  = fire_i ? (cfg_part + id_part) : '0;
    end

endmodule

// File: rtl/image_cksum.sv
module image_cksum
    import image_cksum_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              prot_i,
    input  logic              pw_valid_i,
    input  logic              pw_last_i,
    input  logic [ADDR_W-1:0] pw_addr_i,
    input  logic [WORD_W-1:0] pw_data_i,
    input  logic              meta_valid_i,
    input  logic [WORD_W-1:0] cfg_a_i,
    input  logic [WORD_W-1:0] cfg_b_i,
    input  logic [IDS_W-1:0]  id_words_i,
    output logic [SUM_W-1:0]  sum_o,
    output logic              done_o
);

    logic  pw_fire;
    logic  meta_fire;
    logic  prot_q;
    term_t prog_term;
    term_t meta_term;
    logic [SUM_W-1:0] acc_q;

    image_cksum_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .prot_i       (prot_i),
        .pw_valid_i   (pw_valid_i),
        .pw_last_i    (pw_last_i),
        .meta_valid_i (meta_valid_i),
        .pw_fire_o    (pw_fire),
        .meta_fire_o  (meta_fire),
        .prot_q_o     (prot_q),
        .done_o       (done_o)
    );

    image_cksum_prog_term u_prog (
        .fire_i (pw_fire),
        .prot_i (prot_q),
        .addr_i (pw_addr_i),
        .data_i (pw_data_i),
        .term_o (prog_term)
    );

    image_cksum_meta_term u_meta (
        .fire_i  (meta_fire),
        .prot_i  (prot_q),
        .cfg_a_i (cfg_a_i),
        .cfg_b_i (cfg_b_i),
        .ids_i   (id_words_i),
        .term_o  (meta_term)
    );

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            acc_q <= '0;
        end else if (prog_term.take || meta_term.take) begin
            acc_q <= acc_q + prog_term.val + meta_term.val;
        end
    end

    assign sum_o = acc_q;

endmodule

// File: rtl/image_cksum_chk.sv
module image_cksum_chk
    import image_cksum_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              prot_i,
    input logic              pw_valid_i,
    input logic [ADDR_W-1:0] pw_addr_i,
    input logic              meta_valid_i,
    input logic [SUM_W-1:0]  sum_o,
    input logic              done_o
);

    logic prot_seen;

    always_ff @(posedge clk) begin
        if (rst)          prot_seen <= 1'b0;
        else if (start_i) prot_seen <= prot_i;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (sum_o == '0) && !done_o);

    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (sum_o == '0) && !done_o);

    a_r4_high_addr_skip: assert property (@(posedge clk) disable iff (rst)
        (pw_valid_i && (pw_addr_i > PROG_TOP) && !meta_valid_i && !start_i) |=> $stable(sum_o));

    a_r5_protected_skip: assert property (@(posedge clk) disable iff (rst)
        (prot_seen && !meta_valid_i && !start_i) |=> $stable(sum_o));

    a_r10_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o && $stable(sum_o));

endmodule

bind image_cksum image_cksum_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .prot_i       (prot_i),
    .pw_valid_i   (pw_valid_i),
    .pw_addr_i    (pw_addr_i),
    .meta_valid_i (meta_valid_i),
    .sum_o        (sum_o),
    .done_o       (done_o)
);

// File: tb/image_cksum_tb_top.sv
module image_cksum_tb_top;
    import image_cksum_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic        prot;
        logic [13:0] c1;
        logic [13:0] c2;
        logic [55:0] ids;
        logic [12:0] n;
        logic [13:0] seed;
        logic [13:0] base;
        logic [12:0] meta_at;
        logic        dup;
        logic [3:0]  extra;
    } vec_t;

    localparam int NVEC = 6;
    // seed 0 means every word is the erased value 0x3FFF
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 14'h3FFF, 14'h3FFF, {4{14'h3FFF}}, 13'd4096, 14'h0000, 14'h0000, 13'd4096, 1'b0, 4'd0},
        '{1'b0, 14'h3ABC, 14'h3FFE, {14'h3FF4, 14'h2A03, 14'h0012, 14'h3FF1}, 13'd20, 14'h1234, 14'h0010, 13'd5, 1'b1, 4'd0},
        '{1'b1, 14'h1F00, 14'h0001, {14'h3FF4, 14'h2A03, 14'h0012, 14'h3FF1}, 13'd12, 14'h2222, 14'h0000, 13'd11, 1'b0, 4'd0},
        '{1'b0, 14'h0123, 14'h0002, {14'h0005, 14'h0006, 14'h0007, 14'h0008}, 13'd16, 14'h0777, 14'h0FF8, 13'd0, 1'b0, 4'd0},
        '{1'b1, 14'h2345, 14'h3FFF, {14'h000F, 14'h3FFA, 14'h0000, 14'h1239}, 13'd16, 14'h0333, 14'h0FF8, 13'd16, 1'b0, 4'd0},
        '{1'b0, 14'h3FFF, 14'h0000, {4{14'h0000}}, 13'd300, 14'h3FFF, 14'h0100, 13'd300, 1'b0, 4'd5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        prot_i = 1'b0;
    logic        pw_valid_i = 1'b0;
    logic        pw_last_i = 1'b0;
    logic [13:0] pw_addr_i = '0;
    logic [13:0] pw_data_i = '0;
    logic        meta_valid_i = 1'b0;
    logic [13:0] cfg_a_i = '0;
    logic [13:0] cfg_b_i = '0;
    logic [55:0] id_words_i = '0;
    logic [15:0] sum_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    image_cksum dut_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .prot_i       (prot_i),
        .pw_valid_i   (pw_valid_i),
        .pw_last_i    (pw_last_i),
        .pw_addr_i    (pw_addr_i),
        .pw_data_i    (pw_data_i),
        .meta_valid_i (meta_valid_i),
        .cfg_a_i      (cfg_a_i),
        .cfg_b_i      (cfg_b_i),
        .id_words_i   (id_words_i),
        .sum_o        (sum_o),
        .done_o       (done_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] word_at(input logic [13:0] seed, input int i);
        if (seed == 14'h0) return 14'h3FFF;
        return 14'((int'(seed) * (i + 3)) + (i * 7));
    endfunction

    function automatic logic [15:0] model(input vec_t v);
        int unsigned e = 0;
        for (int i = 0; i < int'(v.n); i++) begin
            logic [13:0] a;
            a = v.base + 14'(i);
            if (!v.prot && a <= 14'h0FFF) e += int'(word_at(v.seed, i));
        end
        e += int'(v.c1 & 14'h3FFF) + int'(v.c2 & 14'h0003);
        if (v.prot) e += int'({v.ids[3:0], v.ids[17:14], v.ids[31:28], v.ids[45:42]});
        return e[15:0];
    endfunction

    task automatic run_vec(input vec_t v, input int idx);
        logic [15:0] exp;
        exp = model(v);
        cfg_a_i    = v.c1;
        cfg_b_i    = v.c2;
        id_words_i = v.ids;
        // start with a word and metadata in the same cycle: both must be dropped (R2)
        start_i = 1'b1; prot_i = v.prot;
        pw_valid_i = 1'b1; pw_addr_i = 14'h0; pw_data_i = 14'h3FFF; meta_valid_i = 1'b1;
        tick();
        start_i = 1'b0; prot_i = 1'b0;
        for (int i = 0; i < int'(v.n); i++) begin
            pw_valid_i   = 1'b1;
            pw_addr_i    = v.base + 14'(i);
            pw_data_i    = word_at(v.seed, i);
            pw_last_i    = (i == int'(v.n) - 1);
            meta_valid_i = (i == int'(v.meta_at)) || (v.dup && i == int'(v.meta_at) + 1);
            tick();
        end
        meta_valid_i = 1'b0; pw_last_i = 1'b0; pw_valid_i = 1'b0;
        if (int'(v.meta_at) >= int'(v.n)) begin
            for (int e = 0; e < int'(v.extra); e++) begin
                pw_valid_i = 1'b1; pw_last_i = 1'b1;
                pw_addr_i = 14'(e); pw_data_i = 14'h1555;
                tick();
            end
            pw_valid_i = 1'b0; pw_last_i = 1'b0;
            meta_valid_i = 1'b1;
            tick();
            meta_valid_i = 1'b0;
        end
        // R3 R4 R5 R6 R7 R8 R10: final sum against the requirement model
        chk($sformatf("R3/R6 vec%0d sum", idx), sum_o, exp);
        // R9: done still low right after the closing edge
        chk($sformatf("R9 vec%0d done early", idx), {15'b0, done_o}, 16'h0000);
        tick();
        chk($sformatf("R9 vec%0d done", idx), {15'b0, done_o}, 16'h0001);
    endtask

    initial begin
        int cnt = 0;
        while (cnt < WATCHDOG) begin
            @(posedge clk);
            cnt++;
            cycles = cnt;
        end
        errors++;
        $display("FAIL watchdog actual=%0d expected<%0d", cnt, WATCHDOG);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] held;
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        tick();
        chk("R1 reset sum", sum_o, 16'h0000);
        chk("R1 reset done", {15'b0, done_o}, 16'h0000);

        // R10: idle before any start, stimulus ignored
        pw_valid_i = 1'b1; pw_last_i = 1'b1; pw_addr_i = 14'h10; pw_data_i = 14'h0ABC;
        meta_valid_i = 1'b1; cfg_a_i = 14'h1111; cfg_b_i = 14'h3;
        tick(); tick();
        pw_valid_i = 1'b0; pw_last_i = 1'b0; meta_valid_i = 1'b0;
        chk("R10 idle sum", sum_o, 16'h0000);
        chk("R10 idle done", {15'b0, done_o}, 16'h0000);

        for (int k = 0; k < NVEC; k++) run_vec(VECS[k], k);

        // R8: blank unprotected image yields 0x3002
        run_vec(VECS[0], 0);
        chk("R8 blank value", sum_o, 16'h3002);
        // R7: nibbles 1,2,3,4 pack to 0x1234 on top of 0x1F00 + 1
        run_vec(VECS[2], 2);
        chk("R7 packed id", sum_o, 16'h3135);

        // R10: after done, further words and metadata are ignored
        held = sum_o;
        pw_valid_i = 1'b1; pw_addr_i = 14'h20; pw_data_i = 14'h0777; meta_valid_i = 1'b1;
        tick(); tick(); tick();
        pw_valid_i = 1'b0; meta_valid_i = 1'b0;
        chk("R10 hold sum", sum_o, held);
        chk("R10 hold done", {15'b0, done_o}, 16'h0001);

        // R2: start clears sum and done
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        chk("R2 start sum", sum_o, 16'h0000);
        chk("R2 start done", {15'b0, done_o}, 16'h0000);

        // R9: metadata alone does not complete a run
        meta_valid_i = 1'b1; cfg_a_i = 14'h0004; cfg_b_i = 14'h0001;
        tick();
        meta_valid_i = 1'b0;
        tick(); tick();
        chk("R9 meta only sum", sum_o, 16'h0005);
        chk("R9 meta only done", {15'b0, done_o}, 16'h0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule